// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Event Detection

This block serves one bank of general-purpose pins behind a small synchronous register port. Every pin owns a control word. Software uses that word to choose direction, output level, pull setting and event mode. The same word, when read, returns the pin's synchronized input level and its pending event flag. A separate bank-wide word gathers the pending flags of all pins into one read. A plain pad-enable word stands in for pin muxing.

Each pin can detect five kinds of event: rising edge, falling edge, either edge, low level or high level. Three mode bits select the kind. A detected event latches a pending flag. Software clears the flag by writing a one to it, so writing back a control word it has just read acknowledges the event. The bank drives one registered interrupt line. That line is high while any pin has both its pending flag and its enable bit set.

Top module: `gpio_irq_bank`

## Requirements
- R1: Address map, in bytes. The control word of pin i is at i*4 (the low two address bits are ignored). The pad-enable word is at 0x84 and the bank status word is at 0x8C. Reading any other address returns 0. Read data is registered and is valid the cycle after the request (sel=1, wr=0).
- R2: Control word fields. Bit0 selects low/falling, bit1 selects high/rising, bit2 selects the mode type (1 edge, 0 level), bit3 is interrupt enable, bit4 is pending status, bit5 is output enable, bit6 is output data, bit7 is the input level, bit8 is pull enable and bit9 is pull direction (1 up). Bits 0-3, 5, 6, 8 and 9 read back as written. Bit7 is read-only.
- R3: After reset every control word reads 0, so all pins are inputs with events masked. The pad-enable word, the status word, pin_oe and irq are all 0.
- R4: A control write that sets bit5 stores interrupt enable as 0, whatever bit3 holds.
- R5: pin_oe[i], pin_out[i], pull_en[i] and pull_up[i] follow bits 5, 6, 8 and 9 of pin i's word. A pin with bit5 at 0 is released and does not drive.
- R6: The input passes through a two-flop synchronizer. Bit7 shows the pin level two clock edges after the pin changes.
- R7: Edge modes. Bits {2,1,0} = 110 detects rising edges, 101 detects falling edges and 111 detects both. A matching edge of the synchronized input sets the pending bit.
- R8: Level modes. Bits {2,1,0} = 010 detects a high level and 001 detects a low level. Any other code with bit2 = 0 detects nothing. While the level condition holds, the pending bit is set on every cycle, so it comes back after it is cleared.
- R9: Writing bit4 = 1 clears the pending bit. Writing bit4 = 0 leaves it unchanged. An event in the same cycle as a clear keeps the bit set.
- R10: Bit i of the status word at 0x8C is pin i's pending bit. Writes to that address have no effect.
- R11: irq is registered. It is the OR over all pins of (pending AND enable). A pending bit on a pin whose enable is 0 never raises irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside the block |
| sel | input | 1 | Register access request |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Byte address inside the bank window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Pad input levels |
| pin_oe | output | 32 | Per-pin drive enable |
| pin_out | output | 32 | Per-pin output level |
| pull_en | output | 32 | Per-pin pull enable |
| pull_up | output | 32 | Per-pin pull direction (1 up) |
| pad_en | output | 32 | Pad-enable word |
| irq | output | 1 | Combined registered interrupt |

## Verification
Read data arrives one cycle after the request. The pin outputs and the pad-enable word follow a write at the same edge that takes it. A pin change reaches bit7 after two edges. The pending bit follows at the third edge and irq at the fourth. The bench changes a pin on a falling edge and then waits at least five cycles before it reads or samples irq, so every result is sampled well after it settles. It reads back only through the register port, and it samples ports on falling edges.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  // control word bit positions (the decoding depends on these)
  localparam int B_LOW  = 0;
  localparam int B_HIGH = 1;
  localparam int B_TYPE = 2;
  localparam int B_IEN  = 3;
  localparam int B_PEND = 4;
  localparam int B_OE   = 5;
  localparam int B_DOUT = 6;
  localparam int B_DIN  = 7;
  localparam int B_PUEN = 8;
  localparam int B_PUUP = 9;
  localparam int CTRL_W = 10;

  typedef struct packed {
    logic pull_up;
    logic pull_en;
    logic dout;
    logic oe;
    logic ien;
    logic itype;
    logic ihigh;
    logic ilow;
  } pin_cfg_t;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);

  logic [1:0] rs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= '0;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end

  assign rst_core_n = rs_q[1];

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_n;

  always_comb begin
    stg_n[0] = d;
    for (int k = 1; k < STAGES; k++) begin
      stg_n[k] = stg_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q <= stg_n;
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              din,
  output logic [CTRL_W-1:0] ctrl_rd,
  output logic              pend,
  output logic              ien,
  output logic              oe,
  output logic              dout,
  output logic              pu_en,
  output logic              pu_up
);

  pin_cfg_t cfg_q, cfg_n;
  logic     pend_q, pend_n;
  logic     prev_q;
  logic     rise, fall, ev;
  logic     unused_wbits;

  assign unused_wbits = wdata[B_DIN];

  // event detection on the synchronized level
  always_comb begin
    rise = din & ~prev_q;
    fall = ~din & prev_q;
    if (cfg_q.itype) begin
      ev = (cfg_q.ihigh & rise) | (cfg_q.ilow & fall);
    end else begin
      ev = (cfg_q.ihigh & ~cfg_q.ilow & din) | (cfg_q.ilow & ~cfg_q.ihigh & ~din);
    end
  end

  // next state: configuration and pending flag
  always_comb begin
    cfg_n = cfg_q;
    if (wr_en) begin
      cfg_n.ilow    = wdata[B_LOW];
      cfg_n.ihigh   = wdata[B_HIGH];
      cfg_n.itype   = wdata[B_TYPE];
      cfg_n.ien     = wdata[B_IEN] & ~wdata[B_OE];
      cfg_n.oe      = wdata[B_OE];
      cfg_n.dout    = wdata[B_DOUT];
      cfg_n.pull_en = wdata[B_PUEN];
      cfg_n.pull_up = wdata[B_PUUP];
    end
    pend_n = ev | (pend_q & ~(wr_en & wdata[B_PEND]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      pend_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_n;
      pend_q <= pend_n;
      prev_q <= din;
    end
  end

  always_comb begin
    ctrl_rd         = '0;
    ctrl_rd[B_LOW]  = cfg_q.ilow;
    ctrl_rd[B_HIGH] = cfg_q.ihigh;
    ctrl_rd[B_TYPE] = cfg_q.itype;
    ctrl_rd[B_IEN]  = cfg_q.ien;
    ctrl_rd[B_PEND] = pend_q;
    ctrl_rd[B_OE]   = cfg_q.oe;
    ctrl_rd[B_DOUT] = cfg_q.dout;
    ctrl_rd[B_DIN]  = din;
    ctrl_rd[B_PUEN] = cfg_q.pull_en;
    ctrl_rd[B_PUUP] = cfg_q.pull_up;
  end

  assign pend  = pend_q;
  assign ien   = cfg_q.ien;
  assign oe    = cfg_q.oe;
  assign dout  = cfg_q.dout;
  assign pu_en = cfg_q.pull_en;
  assign pu_up = cfg_q.pull_up;

endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pend,
  input  logic [N-1:0] ien,
  output logic         irq
);

  logic irq_q, irq_n;

  always_comb begin
    irq_n = |(pend & ien);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_n;
    end
  end

  assign irq = irq_q;

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int                NUM_PINS    = 32,
  parameter int                ADDR_W      = 8,
  parameter int                DATA_W      = 32,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] PAD_OFS     = 8'h84,
  parameter logic [ADDR_W-1:0] STAT_OFS    = 8'h8C
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel,
  input  logic                wr,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pull_en,
  output logic [NUM_PINS-1:0] pull_up,
  output logic [DATA_W-1:0]   pad_en,
  output logic                irq
);

  localparam int              WIDX_W   = ADDR_W - 2;
  localparam logic [ADDR_W:0] CTRL_END = (ADDR_W+1)'(NUM_PINS * 4);

  logic                             rst_core_n;
  logic [NUM_PINS-1:0]              din_s;
  logic [NUM_PINS-1:0]              status_vec;
  logic [NUM_PINS-1:0]              ien_vec;
  logic [NUM_PINS-1:0][CTRL_W-1:0]  ctrl_rd;
  logic [NUM_PINS-1:0]              ctrl_wr;
  logic [WIDX_W-1:0]                widx;
  logic                             in_ctrl;
  logic                             wr_req, rd_req, pad_wr;
  logic [DATA_W-1:0]                pad_q, pad_n;
  logic [DATA_W-1:0]                rdata_q, rdata_n;
  logic                             unused_bits;

  assign unused_bits = ^{addr[1:0], wdata[DATA_W-1:CTRL_W]};

  gpio_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  gpio_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d     (pin_in),
    .q     (din_s)
  );

  // access decode
  assign wr_req  = sel & wr;
  assign rd_req  = sel & ~wr;
  assign widx    = addr[ADDR_W-1:2];
  assign in_ctrl = ({1'b0, addr} < CTRL_END);
  assign pad_wr  = wr_req & (addr == PAD_OFS);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign ctrl_wr[p] = wr_req & in_ctrl & (widx == WIDX_W'(p));

    gpio_pin_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .wr_en   (ctrl_wr[p]),
      .wdata   (wdata[CTRL_W-1:0]),
      .din     (din_s[p]),
      .ctrl_rd (ctrl_rd[p]),
      .pend    (status_vec[p]),
      .ien     (ien_vec[p]),
      .oe      (pin_oe[p]),
      .dout    (pin_out[p]),
      .pu_en   (pull_en[p]),
      .pu_up   (pull_up[p])
    );
  end

  gpio_irq_merge #(.N(NUM_PINS)) u_merge (
    .clk   (clk),
    .rst_n (rst_core_n),
    .pend  (status_vec),
    .ien   (ien_vec),
    .irq   (irq)
  );

  // pad-enable word
  always_comb begin
    pad_n = pad_q;
    if (pad_wr) begin
      pad_n = wdata;
    end
  end

  // read mux
  always_comb begin
    rdata_n = '0;
    if (addr == PAD_OFS) begin
      rdata_n = pad_q;
    end else if (addr == STAT_OFS) begin
      rdata_n = DATA_W'(status_vec);
    end else if (in_ctrl) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (widx == WIDX_W'(p)) begin
          rdata_n = DATA_W'(ctrl_rd[p]);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      pad_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (pad_wr) begin
        pad_q <= pad_n;
      end
      if (rd_req) begin
        rdata_q <= rdata_n;
      end
    end
  end

  assign pad_en = pad_q;
  assign rdata  = rdata_q;

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int                NUM_PINS = 32,
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 32,
  parameter logic [ADDR_W-1:0] PAD_OFS  = 8'h84,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h8C
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sel,
  input logic                wr,
  input logic [ADDR_W-1:0]   addr,
  input logic [DATA_W-1:0]   pad_en,
  input logic [DATA_W-1:0]   rdata,
  input logic                irq,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic [NUM_PINS-1:0] status_vec,
  input logic [NUM_PINS-1:0] ien_vec
);

  AST_IRQ_FOLLOWS_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(status_vec & ien_vec)))); // R11

  AST_OUTPUT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe & ien_vec) == '0)); // R4

  AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !wr && addr == STAT_OFS) |=> (rdata == DATA_W'($past(status_vec)))); // R10

  AST_PAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && wr && addr == PAD_OFS) |=> $stable(pad_en)); // R1

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(
  .NUM_PINS (NUM_PINS),
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .PAD_OFS  (PAD_OFS),
  .STAT_OFS (STAT_OFS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .sel        (sel),
  .wr         (wr),
  .addr       (addr),
  .pad_en     (pad_en),
  .rdata      (rdata),
  .irq        (irq),
  .pin_oe     (pin_oe),
  .status_vec (status_vec),
  .ien_vec    (ien_vec)
);

// File: tb/sim_gpio_irq_bank.sv
`timescale 1ns/1ps
module sim_gpio_irq_bank;

  localparam int NP = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sel, wr;
  logic [7:0]    addr;
  logic [31:0]   wdata, rdata;
  logic [NP-1:0] pin_in, pin_oe, pin_out, pull_en, pull_up;
  logic [31:0]   pad_en;
  logic          irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_bank u0 (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_oe(pin_oe),
    .pin_out(pin_out), .pull_en(pull_en), .pull_up(pull_up),
    .pad_en(pad_en), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a;
    @(negedge clk);
    sel = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // level condition for mode bits {type, high, low}
  function automatic bit lvl(input logic [2:0] m, input bit v);
    if (m[2]) return 1'b0;
    return (m[1] & ~m[0] & v) | (m[0] & ~m[1] & ~v);
  endfunction

  function automatic bit edg(input logic [2:0] m, input bit rising);
    return m[2] & (rising ? m[1] : m[0]);
  endfunction

  initial begin
    int wd = 0;
    while (!done && wd < 150000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; sel = 1'b0; wr = 1'b0; addr = '0; wdata = '0; pin_in = '0;
    idle(5);
    rst_n = 1'b1;
    idle(4);

    // R3 reset state
    rd_reg(8'h00, d);           check("R3 ctrl0", d, 32'h0);
    rd_reg(8'h7C, d);           check("R3 ctrl31", d, 32'h0);
    rd_reg(8'h84, d);           check("R3 pad", d, 32'h0);
    rd_reg(8'h8C, d);           check("R3 status", d, 32'h0);
    check("R3 irq", {31'b0, irq}, 32'h0);
    check("R3 pin_oe", pin_oe, 32'h0);

    // R1 address map
    wr_reg(8'h84, 32'hDEADBEEF);
    rd_reg(8'h84, d);           check("R1 pad readback", d, 32'hDEADBEEF);
    check("R1 pad port", pad_en, 32'hDEADBEEF);
    rd_reg(8'h80, d);           check("R1 unmapped 0x80", d, 32'h0);
    rd_reg(8'h88, d);           check("R1 unmapped 0x88", d, 32'h0);

    // R4 / R5 output control and forced mask
    wr_reg(8'h0C, 32'h368);
    rd_reg(8'h0C, d);           check("R4 ien cleared on OE", d, 32'h360);
    check("R5 pin_oe", pin_oe, 32'h8);
    check("R5 pin_out", pin_out, 32'h8);
    check("R5 pull_en", pull_en, 32'h8);
    check("R5 pull_up", pull_up, 32'h8);
    wr_reg(8'h0C, 32'h148);
    rd_reg(8'h0C, d);           check("R5 input with ien", d, 32'h148);
    check("R5 released", pin_oe, 32'h0);
    check("R5 pull down", pull_up, 32'h0);
    wr_reg(8'h0C, 32'h0);

    // R2 bit layout: bit7 read-only, writable mask
    wr_reg(8'h14, 32'h80);
    rd_reg(8'h14, d);           check("R2 din read-only", d, 32'h0);
    wr_reg(8'h14, 32'hFFFFFFFF);
    rd_reg(8'h14, d);           check("R2 writable fields", d, 32'h367);
    wr_reg(8'h14, 32'h0);
    wr_reg(8'h14, 32'h10);

    // R10 status word ignores writes; R11 masked pending
    wr_reg(8'h1C, 32'h06);
    pin_in[7] = 1'b1;
    idle(5);
    rd_reg(8'h8C, d);           check("R10 status bit7", d, 32'h80);
    check("R11 masked pending no irq", {31'b0, irq}, 32'h0);
    wr_reg(8'h8C, 32'hFFFFFFFF);
    rd_reg(8'h8C, d);           check("R10 write ignored ones", d, 32'h80);
    wr_reg(8'h8C, 32'h0);
    rd_reg(8'h8C, d);           check("R10 write ignored zeros", d, 32'h80);
    wr_reg(8'h1C, 32'h0E);
    idle(3);
    check("R11 irq on enable", {31'b0, irq}, 32'h1);
    wr_reg(8'h1C, 32'h1E);
    idle(3);
    check("R11 irq drops after clear", {31'b0, irq}, 32'h0);
    wr_reg(8'h1C, 32'h0);
    pin_in[7] = 1'b0;
    idle(5);
    wr_reg(8'h1C, 32'h10);

    // R6..R9, R11 sweep over every pin, mode code and enable
    for (int i = 0; i < NP; i++) begin
      for (int m = 0; m < 8; m++) begin
        for (int en = 0; en < 2; en++) begin
          logic [7:0]  a;
          logic [31:0] cw;
          bit st;
          a  = 8'(i * 4);
          cw = 32'(m) | (32'(en) << 3);
          pin_in = '0;
          idle(5);
          wr_reg(a, cw | 32'h10);
          idle(5);
          st = lvl(3'(m), 1'b0);
          rd_reg(a, d);  check("R8 level at low input", d, cw | (32'(st) << 4));
          check("R11 irq low input", {31'b0, irq}, 32'(st & en[0]));

          wr_reg(a, cw | 32'h10);
          pin_in[i] = 1'b1;
          idle(5);
          st = lvl(3'(m), 1'b0) | lvl(3'(m), 1'b1) | edg(3'(m), 1'b1);
          rd_reg(a, d);  check("R7 rise detect / R6 din", d, cw | (32'(st) << 4) | 32'h80);
          rd_reg(8'h8C, d); check("R10 status after rise", d, 32'(st) << i);
          check("R11 irq after rise", {31'b0, irq}, 32'(st & en[0]));

          wr_reg(a, cw);
          idle(2);
          rd_reg(a, d);  check("R9 zero write keeps pending", d, cw | (32'(st) << 4) | 32'h80);

          wr_reg(a, cw | 32'h10);
          idle(3);
          st = lvl(3'(m), 1'b1);
          rd_reg(a, d);  check("R9 clear / R8 re-set", d, cw | (32'(st) << 4) | 32'h80);

          wr_reg(a, cw | 32'h10);
          pin_in[i] = 1'b0;
          idle(5);
          st = lvl(3'(m), 1'b1) | lvl(3'(m), 1'b0) | edg(3'(m), 1'b0);
          rd_reg(a, d);  check("R7 fall detect", d, cw | (32'(st) << 4));

          wr_reg(a, 32'h0);
          wr_reg(a, 32'h10);
        end
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule